// File: doc/BRIEF.md
# RTC Calibration and Alarm Output Unit

This unit drives the two output pins of a real-time clock from the 32.768 kHz clock domain. A two-stage down-counting prescaler (a 7-bit fast stage feeding a 15-bit slow stage) divides the clock down to a one-cycle 1 Hz tick. With the default reload values of 127 and 255, the division is exactly 32768.

The calibration pin brings out a tap of the prescaler chain. One tap is a 512 Hz square wave from the fast stage. The other is a 1 Hz square wave from the slow stage. An enable bit gates the pin.

The alarm pin mirrors one of two externally generated flags: the alarm flag or the wakeup flag. A two-bit select chooses the flag and a polarity bit sets the active level. The pin is registered so that it never glitches. The calendar and the flag generation sit outside this block.

Top module: `rtc_calout_unit`

## Requirements
- R1: The fast stage counts down by one each cycle. On reaching 0 it reloads from `async_reload_i`, so its period is A+1 cycles, where A is the reload value. Reset sets it to 127.
- R2: The slow stage decrements only in a cycle where the fast stage reloads, and it reloads from `sync_reload_i` (value S) on reaching 0. Reset sets it to 255. `tick_1hz_o` is high for exactly one cycle when both stages are at 0, so ticks repeat every (A+1)*(S+1) cycles, which is 32768 at the defaults.
- R3: A new reload value written mid-period does not disturb the current countdown. It is used first at the next reload of that stage.
- R4: With `cal_en_i`=1 and `cal_sel_i`=0, `cal_o` equals bit 5 of the fast-stage count. At the defaults this is a 64-cycle square wave with 32 cycles high and 32 cycles low (512 Hz).
- R5: With `cal_en_i`=1 and `cal_sel_i`=1, `cal_o` equals bit 7 of the slow-stage count. At the defaults this is a 32768-cycle square wave with 50% duty (1 Hz).
- R6: With `cal_en_i`=0, `cal_o` is 0 whatever the select and count state.
- R7: The `out_sel_i` encoding is 2'b01 for the alarm flag and 2'b11 for the wakeup flag. `alarm_o` is registered and reflects the inputs sampled at the previous clock edge.
- R8: With `pol_i`=0, `alarm_o` is high when the selected flag is 1. With `pol_i`=1 it is low when the flag is 1, that is `alarm_o` = flag XOR `pol_i`.
- R9: The `out_sel_i` values 2'b00 (off) and 2'b10 (reserved) hold `alarm_o` at the inactive level, which equals `pol_i`. Both flags are ignored.
- R10: During reset `alarm_o` and `tick_1hz_o` are 0, and `cal_o` is 0 while `cal_en_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32.768 kHz RTC clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| async_reload_i | input | 7 | Fast-stage reload value |
| sync_reload_i | input | 15 | Slow-stage reload value |
| cal_en_i | input | 1 | Calibration pin enable |
| cal_sel_i | input | 1 | Calibration tap: 0 fast stage (512 Hz), 1 slow stage (1 Hz) |
| out_sel_i | input | 2 | Alarm pin source: 00 off, 01 alarm, 10 reserved, 11 wakeup |
| pol_i | input | 1 | Alarm pin polarity: 0 active high, 1 active low |
| alarm_flag_i | input | 1 | Alarm flag |
| wake_flag_i | input | 1 | Wakeup flag |
| tick_1hz_o | output | 1 | One-cycle 1 Hz tick |
| cal_o | output | 1 | Calibration output |
| alarm_o | output | 1 | Alarm/wakeup output |

## Verification
The hardest behaviour to reach from the ports is the 1 Hz calibration waveform at the default reload values, because one period takes 32768 cycles. The bench lets more than two full periods run while it compares every cycle against an arithmetic model of both stages.

The next hardest case is a reload write that lands in the middle of a period. To reach it, the bench waits for a tick, changes one reload value a few cycles later, and measures that the following interval still follows the old value while the interval after it follows the new one. The tick period itself is swept over a small grid of fast and slow reload values, and every output-select, polarity and flag combination is applied.

// File: rtl/rtc_out_pkg.sv
package rtc_out_pkg;
  typedef enum logic [1:0] {
    OSEL_OFF   = 2'b00,
    OSEL_ALARM = 2'b01,
    OSEL_RSVD  = 2'b10,
    OSEL_WAKE  = 2'b11
  } out_sel_e;

  localparam int unsigned FAST_W   = 7;
  localparam int unsigned SLOW_W   = 15;
  localparam int unsigned FAST_DEF = 127;
  localparam int unsigned SLOW_DEF = 255;
endpackage

// File: rtl/rtc_down_div.sv
module rtc_down_div #(
  parameter int unsigned W       = 7,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = en_i && (cnt_q == '0);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= RST_VAL;
    else if (wrap_o)  cnt_q <= reload_i;
    else if (en_i)    cnt_q <= cnt_q - W'(1);
  end

  p_dec_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));
  p_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q == '0) |=> (cnt_q == $past(reload_i)));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_cal_tap.sv
module rtc_cal_tap #(
  parameter int unsigned FAST_W   = 7,
  parameter int unsigned SLOW_W   = 15,
  parameter int unsigned FAST_BIT = 5,
  parameter int unsigned SLOW_BIT = 7
) (
  input  logic              rst_ni,
  input  logic [FAST_W-1:0] fast_cnt_i,
  input  logic [SLOW_W-1:0] slow_cnt_i,
  input  logic              en_i,
  input  logic              sel_i,
  output logic              cal_o
);
  logic tap;
  assign tap   = sel_i ? slow_cnt_i[SLOW_BIT] : fast_cnt_i[FAST_BIT];
  assign cal_o = en_i & tap;

  always_comb begin
    if (rst_ni && !en_i) p_cal_off_r6: assert (!cal_o);
  end
endmodule

// File: rtl/rtc_flag_out.sv
module rtc_flag_out
  import rtc_out_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] out_sel_i,
  input  logic       pol_i,
  input  logic       alarm_flag_i,
  input  logic       wake_flag_i,
  output logic       alarm_o
);
  logic act;

  always_comb begin
    unique case (out_sel_e'(out_sel_i))
      OSEL_ALARM: act = alarm_flag_i;
      OSEL_WAKE:  act = wake_flag_i;
      default:    act = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alarm_o <= 1'b0;
    else         alarm_o <= act ^ pol_i;
  end

  p_off_inactive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_sel_i == 2'b00 || out_sel_i == 2'b10) |=> (alarm_o == $past(pol_i)));
  p_alarm_pol_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_sel_i == 2'b01) |=> (alarm_o == ($past(alarm_flag_i) ^ $past(pol_i))));
  p_wake_pol_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_sel_i == 2'b11) |=> (alarm_o == ($past(wake_flag_i) ^ $past(pol_i))));
endmodule

// File: rtl/rtc_calout_unit.sv
module rtc_calout_unit
  import rtc_out_pkg::*;
#(
  parameter int unsigned A_W      = FAST_W,
  parameter int unsigned S_W      = SLOW_W,
  parameter int unsigned A_DEF    = FAST_DEF,
  parameter int unsigned S_DEF    = SLOW_DEF,
  parameter int unsigned FAST_BIT = 5,
  parameter int unsigned SLOW_BIT = 7
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [A_W-1:0] async_reload_i,
  input  logic [S_W-1:0] sync_reload_i,
  input  logic           cal_en_i,
  input  logic           cal_sel_i,
  input  logic [1:0]     out_sel_i,
  input  logic           pol_i,
  input  logic           alarm_flag_i,
  input  logic           wake_flag_i,
  output logic           tick_1hz_o,
  output logic           cal_o,
  output logic           alarm_o
);
  logic [A_W-1:0] a_cnt;
  logic [S_W-1:0] s_cnt;
  logic           a_wrap;

  rtc_down_div #(.W(A_W), .RST_VAL(A_W'(A_DEF))) u_fast (
    .clk_i, .rst_ni, .en_i(1'b1), .reload_i(async_reload_i),
    .cnt_o(a_cnt), .wrap_o(a_wrap)
  );

  rtc_down_div #(.W(S_W), .RST_VAL(S_W'(S_DEF))) u_slow (
    .clk_i, .rst_ni, .en_i(a_wrap), .reload_i(sync_reload_i),
    .cnt_o(s_cnt), .wrap_o(tick_1hz_o)
  );

  rtc_cal_tap #(.FAST_W(A_W), .SLOW_W(S_W), .FAST_BIT(FAST_BIT), .SLOW_BIT(SLOW_BIT)) u_cal (
    .rst_ni, .fast_cnt_i(a_cnt), .slow_cnt_i(s_cnt),
    .en_i(cal_en_i), .sel_i(cal_sel_i), .cal_o
  );

  rtc_flag_out u_flag (
    .clk_i, .rst_ni, .out_sel_i, .pol_i, .alarm_flag_i, .wake_flag_i, .alarm_o
  );

  p_tick_on_fast_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_1hz_o |=> (a_cnt == $past(async_reload_i)));
endmodule

// File: tb/rtc_calout_unit_bench.sv
module rtc_calout_unit_bench;
  logic clk = 0, rst_n = 0;
  logic [6:0]  ar = 7'd127;
  logic [14:0] sr = 15'd255;
  logic cal_en = 0, cal_sel = 0, pol = 1, aflag = 0, wflag = 0;
  logic [1:0] osel = 2'b00;
  logic tick, cal, alm;
  int n_vec = 0, n_bad = 0;
  int m_a = 127, m_s = 255;
  bit mon_on = 0;

  always #5 clk = ~clk;

  rtc_calout_unit u_rtc_calout_unit (
    .clk_i(clk), .rst_ni(rst_n), .async_reload_i(ar), .sync_reload_i(sr),
    .cal_en_i(cal_en), .cal_sel_i(cal_sel), .out_sel_i(osel), .pol_i(pol),
    .alarm_flag_i(aflag), .wake_flag_i(wflag),
    .tick_1hz_o(tick), .cal_o(cal), .alarm_o(alm)
  );

  // arithmetic model of both stages
  always @(posedge clk) begin
    if (!rst_n) begin m_a = 127; m_s = 255; end
    else if (m_a == 0) begin
      m_a = int'(ar);
      if (m_s == 0) m_s = int'(sr); else m_s = m_s - 1;
    end else m_a = m_a - 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (mon_on) begin
    chk("R2 tick", int'(tick), int'(m_a == 0 && m_s == 0));
    if (!cal_en) chk("R6 cal off", int'(cal), 0);
    else if (cal_sel) chk("R5 cal 1Hz", int'(cal), (m_s >> 7) & 1);
    else chk("R4 cal 512Hz", int'(cal), (m_a >> 5) & 1);
  end

  task automatic wait_tick();
    int lim = 0;
    do begin @(negedge clk); lim++; end while (!tick && lim < 40000);
  endtask

  task automatic measure(input string req, input int exp);
    int n = 0;
    do begin @(negedge clk); n++; end while (!tick && n < 40000);
    chk(req, n, exp);
  endtask

  initial begin
    int hi;
    @(negedge clk);
    chk("R10 alarm in reset", int'(alm), 0);
    chk("R10 tick in reset", int'(tick), 0);
    chk("R10 cal in reset", int'(cal), 0);
    pol = 0;
    @(negedge clk); rst_n = 1; mon_on = 1;

    // R4: 512 Hz, also duty over 4 periods
    cal_en = 1; cal_sel = 0; hi = 0;
    repeat (256) begin @(negedge clk); hi += int'(cal); end
    chk("R4 duty", hi, 128);
    // R5: 1 Hz through more than two full periods
    cal_sel = 1;
    repeat (70000) @(negedge clk);
    // R6: enable off
    cal_en = 0;
    repeat (300) @(negedge clk);

    // R1/R2: period sweep
    for (int a = 0; a < 8; a++)
      for (int s = 0; s < 4; s++) begin
        @(negedge clk); ar = 7'(a); sr = 15'(s);
        wait_tick(); wait_tick();
        measure("R1 R2 period", (a + 1) * (s + 1));
      end

    // R3: slow reload changed mid-period
    ar = 7'd1; sr = 15'd9;
    wait_tick(); wait_tick();
    repeat (3) @(negedge clk);
    sr = 15'd2;
    measure("R3 slow old period", 17);
    measure("R3 slow new period", 6);
    // R3: fast reload changed mid-period
    ar = 7'd4; sr = 15'd0;
    wait_tick(); wait_tick();
    repeat (2) @(negedge clk);
    ar = 7'd1;
    measure("R3 fast old period", 3);
    measure("R3 fast new period", 2);

    // R7/R8/R9: exhaustive alarm pin sweep
    for (int v = 0; v < 32; v++) begin
      int sel, p, fa, fw, act;
      sel = v & 3; p = (v >> 2) & 1; fa = (v >> 3) & 1; fw = (v >> 4) & 1;
      osel = 2'(sel); pol = p[0]; aflag = fa[0]; wflag = fw[0];
      act = (sel == 1) ? fa : (sel == 3) ? fw : 0;
      @(negedge clk);
      if (sel == 0 || sel == 2) chk("R9 inactive level", int'(alm), p);
      else if (sel == 1) chk("R7 R8 alarm select", int'(alm), act ^ p);
      else chk("R7 R8 wake select", int'(alm), act ^ p);
    end

    mon_on = 0;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule